// File: doc/BRIEF.md
# Slot Reset and Power Sequencer

This block drives the power enable and the active-low reset of one downstream hot-plug slot. A level command bit asks for slot power to be off (1) or on (0). When power goes on, the slot stays in reset until one of two release conditions is met. In supply-follow mode, reset is released a fixed number of prescaled ticks after the enable rises. In good-follow mode, reset is released once the slot's power-good input has been seen high on two consecutive clock edges. The mode is chosen by an input bit.

When power is removed, the block always asserts reset first. It holds the supply on for a programmable gap, given in prescaled ticks, and only then drops the enable. A request to power on that arrives during that gap does not cut it short. The request takes effect only after the enable has fallen. After a fundamental reset the slot is unpowered and held in reset.

All timing is counted in clock cycles. One tick is `PRESCALE` cycles, and each interval is restarted when the sequencer changes phase.

Top module: `slot_pwr_seq`

## Requirements
- R1: While `rst_n` is low and afterwards while `pwr_off` stays 1, `slot_pwr_en` is 0 and `slot_rst_n` is 0.
- R2: With the slot unpowered, a clock edge that samples `pwr_off` = 0 raises `slot_pwr_en` at that edge, while `slot_rst_n` stays 0.
- R3: With `mode_pg` = 0 (supply-follow), `slot_rst_n` rises exactly `REL_TICKS*PRESCALE + 1` cycles after `slot_pwr_en` rises.
- R4: With `mode_pg` = 1 (good-follow), `slot_rst_n` rises at the edge that samples `pgood` high for the second edge in a row. A single-cycle high pulse on `pgood` does not release reset.
- R5: With `mode_pg` = 1 and the slot running, an edge that samples `pgood` = 0 drives `slot_rst_n` low at that edge while `slot_pwr_en` stays 1. Release then follows R4 again.
- R6: An edge that samples `pwr_off` = 1 on a powered slot drives `slot_rst_n` low at that edge. `slot_pwr_en` falls exactly `dly_ticks*PRESCALE + 1` cycles later, so a delay of 0 drops power on the next cycle.
- R7: If `pwr_off` returns to 0 during the power-down gap, `slot_pwr_en` still falls on schedule and rises again one cycle after it fell.
- R8: `dly_ticks` is captured on the edge that starts power-down. Changing it during the gap does not change the gap length.
- R9: With `mode_pg` = 0, `pgood` has no effect. A running slot keeps `slot_rst_n` high while `pgood` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous fundamental reset, active low |
| pwr_off | input | 1 | Power controller command: 1 = slot power off, 0 = on |
| mode_pg | input | 1 | Reset release source: 0 = power enable plus fixed delay, 1 = power good |
| dly_ticks | input | DLY_W | Reset-to-power-off gap in prescaled ticks |
| pgood | input | 1 | Slot power-good indication |
| slot_rst_n | output | 1 | Slot reset, active low |
| slot_pwr_en | output | 1 | Slot power enable |

## Verification
A phase register holding the wrong value shows up at the two outputs on the very next clock edge, because both outputs are decoded directly from that register. A timer that miscounts moves the edge where reset releases or where the enable drops, and the error appears at the end of the interval concerned, at most 61 cycles with the bench parameters. The bench runs a cycle-accurate reference beside the design and compares both outputs on every cycle. Any early, late or missing edge is therefore reported in the cycle where it occurs, and directed gap measurements name the requirement involved.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_RAMP  = 2'd1,
    PH_LIVE  = 2'd2,
    PH_DRAIN = 2'd3
  } slot_phase_e;

  // number of clock cycles in a given count of prescaled ticks
  function automatic int tick_cycles(input int ticks, input int pres);
    return ticks * pres;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      lim_q <= limit;
    end else if (cnt_q != {CW{1'b1}}) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q >= lim_q);

  // R3
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !restart |=> expired);

endmodule

// File: rtl/pg_qual.sv
module pg_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic pgood,
  output logic pg_ok
);

  logic pg_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_prev <= 1'b0;
    else        pg_prev <= pgood;
  end

  assign pg_ok = pgood && pg_prev;

  // R4
  pg_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_ok |-> $past(pgood));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import slot_seq_pkg::*;
#(
  parameter int            CW      = 8,
  parameter logic [CW-1:0] REL_CYC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_off,
  input  logic          mode_pg,
  input  logic          pgood,
  input  logic          pg_ok,
  input  logic [CW-1:0] dly_cyc,
  input  logic          tmr_expired,
  output logic          tmr_restart,
  output logic [CW-1:0] tmr_limit,
  output logic          slot_rst_n,
  output logic          slot_pwr_en
);

  slot_phase_e phase_q, phase_d;
  logic        release_ok;

  assign release_ok = mode_pg ? pg_ok : tmr_expired;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_OFF:   if (!pwr_off) phase_d = PH_RAMP;
      PH_RAMP:  if (pwr_off) phase_d = PH_DRAIN;
                else if (release_ok) phase_d = PH_LIVE;
      PH_LIVE:  if (pwr_off) phase_d = PH_DRAIN;
                else if (mode_pg && !pgood) phase_d = PH_RAMP;
      PH_DRAIN: if (tmr_expired) phase_d = PH_OFF;
      default:  phase_d = PH_OFF;
    endcase
  end

  assign tmr_restart = (phase_d != phase_q);
  assign tmr_limit   = (phase_d == PH_DRAIN) ? dly_cyc : REL_CYC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_OFF;
    else        phase_q <= phase_d;
  end

  assign slot_rst_n  = (phase_q == PH_LIVE);
  assign slot_pwr_en = (phase_q != PH_OFF);

  // R2
  on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_pwr_en && !pwr_off |=> slot_pwr_en && !slot_rst_n);

  // R3
  rel_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_rst_n) |-> slot_pwr_en && $past(slot_pwr_en));

  // R4
  pg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_rst_n) && $past(mode_pg) |-> $past(pgood) && $past(pgood, 2));

  // R5
  pg_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rst_n && mode_pg && !pgood |=> !slot_rst_n && slot_pwr_en);

  // R6
  off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slot_pwr_en) |-> !$past(slot_rst_n));

  // R6
  off_rst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rst_n && pwr_off |=> !slot_rst_n && slot_pwr_en);

endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
  import slot_seq_pkg::*;
#(
  parameter int DLY_W     = 4,
  parameter int PRESCALE  = 8,
  parameter int REL_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_off,
  input  logic             mode_pg,
  input  logic [DLY_W-1:0] dly_ticks,
  input  logic             pgood,
  output logic             slot_rst_n,
  output logic             slot_pwr_en
);

  localparam int MAXC    = max2((1 << DLY_W) - 1, REL_TICKS) * PRESCALE;
  localparam int CW      = $clog2(MAXC + 2);
  localparam int REL_CYC = tick_cycles(REL_TICKS, PRESCALE);

  logic [CW-1:0] dly_cyc;
  logic [CW-1:0] tmr_limit;
  logic          tmr_restart;
  logic          tmr_expired;
  logic          pg_ok;

  assign dly_cyc = CW'(tick_cycles(int'(dly_ticks), PRESCALE));

  pg_qual u_pg (
    .clk   (clk),
    .rst_n (rst_n),
    .pgood (pgood),
    .pg_ok (pg_ok)
  );

  seq_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .limit   (tmr_limit),
    .expired (tmr_expired)
  );

  seq_fsm #(.CW(CW), .REL_CYC(CW'(REL_CYC))) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_off     (pwr_off),
    .mode_pg     (mode_pg),
    .pgood       (pgood),
    .pg_ok       (pg_ok),
    .dly_cyc     (dly_cyc),
    .tmr_expired (tmr_expired),
    .tmr_restart (tmr_restart),
    .tmr_limit   (tmr_limit),
    .slot_rst_n  (slot_rst_n),
    .slot_pwr_en (slot_pwr_en)
  );

endmodule

// File: tb/tb_slot_pwr_seq.sv
`timescale 1ns/1ps
module tb_slot_pwr_seq;

  localparam int P   = 4;
  localparam int REL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_off = 1'b1;
  logic       mode_pg = 1'b0;
  logic [3:0] dly_ticks = 4'd0;
  logic       pgood = 1'b0;
  logic       slot_rst_n;
  logic       slot_pwr_en;

  int    n_run = 0;
  int    n_fail = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_pwr = 0, m_rstn = 0, m_drain = 0;
  int m_cnt = 0, m_lim = 0, pg_run = 0;

  always #4 clk = ~clk;

  slot_pwr_seq #(.DLY_W(4), .PRESCALE(P), .REL_TICKS(REL)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_off(pwr_off), .mode_pg(mode_pg),
    .dly_ticks(dly_ticks), .pgood(pgood),
    .slot_rst_n(slot_rst_n), .slot_pwr_en(slot_pwr_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_pwr = 0; m_rstn = 0; m_drain = 0; m_cnt = 0; m_lim = 0; pg_run = 0;
    end else begin
      int  run_n;
      bit  good2;
      run_n = pgood ? pg_run + 1 : 0;
      good2 = (run_n >= 2);
      if (m_drain) begin
        if (m_cnt >= m_lim) begin m_drain = 0; m_pwr = 0; end
        else m_cnt++;
      end else if (!m_pwr) begin
        if (!pwr_off) begin m_pwr = 1; m_cnt = 0; end
      end else if (!m_rstn) begin
        if (pwr_off) begin m_drain = 1; m_cnt = 0; m_lim = int'(dly_ticks) * P; end
        else if (mode_pg ? good2 : (m_cnt >= REL * P)) m_rstn = 1;
        else m_cnt++;
      end else begin
        if (pwr_off) begin m_rstn = 0; m_drain = 1; m_cnt = 0; m_lim = int'(dly_ticks) * P; end
        else if (mode_pg && !pgood) begin m_rstn = 0; m_cnt = 0; end
      end
      pg_run = run_n;
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(slot_pwr_en == m_pwr, {cur_req, " power enable vs model"}, slot_pwr_en, m_pwr);
      chk(slot_rst_n == m_rstn, {cur_req, " reset vs model"}, slot_rst_n, m_rstn);
    end
  end

  // power on in supply-follow mode, measure release delay
  task automatic power_on_pe();
    int n;
    pwr_off = 1'b0;
    @(negedge clk);
    chk(slot_pwr_en && !slot_rst_n, "R2 power rises with reset held", {slot_pwr_en, slot_rst_n}, 2);
    n = 0;
    while (!slot_rst_n && n < 300) begin @(negedge clk); n++; end
    chk(n == REL * P + 1, "R3 release delay", n, REL * P + 1);
  endtask

  // power off; optional mid-gap change of delay or of the command
  task automatic power_off(input int d, input int mid_dly, input bit mid_on, input string req);
    int n;
    cur_req = req;
    dly_ticks = 4'(d);
    pwr_off = 1'b1;
    @(negedge clk);
    chk(!slot_rst_n && slot_pwr_en, {req, " reset before power"}, {slot_rst_n, slot_pwr_en}, 1);
    n = 0;
    while (slot_pwr_en && n < 300) begin
      @(negedge clk); n++;
      if (n == 1) begin
        if (mid_dly >= 0) dly_ticks = 4'(mid_dly);
        if (mid_on) pwr_off = 1'b0;
      end
    end
    chk(n == d * P + 1, {req, " reset-to-off gap"}, n, d * P + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!slot_pwr_en && !slot_rst_n, "R1 in reset", {slot_pwr_en, slot_rst_n}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!slot_pwr_en && !slot_rst_n, "R1 off after reset", {slot_pwr_en, slot_rst_n}, 0);

    cur_req = "R3";
    power_on_pe();

    // R9: pgood ignored in supply-follow mode
    cur_req = "R9";
    for (int i = 0; i < 6; i++) begin
      pgood = i[0];
      @(negedge clk);
      chk(slot_rst_n == 1'b1, "R9 pgood ignored", slot_rst_n, 1);
    end
    pgood = 1'b0;

    power_off(0, -1, 0, "R6");
    cur_req = "R3"; power_on_pe();
    power_off(5, -1, 0, "R6");
    cur_req = "R3"; power_on_pe();
    power_off(15, 0, 0, "R8");
    cur_req = "R3"; power_on_pe();
    power_off(3, -1, 1, "R7");
    @(negedge clk);
    chk(slot_pwr_en == 1'b1, "R7 held power-on applied", slot_pwr_en, 1);
    repeat (REL * P + 2) @(negedge clk);
    power_off(1, -1, 0, "R6");

    // good-follow mode
    cur_req = "R4";
    mode_pg = 1'b1;
    pgood = 1'b0;
    pwr_off = 1'b0;
    repeat (20) @(negedge clk);
    chk(slot_pwr_en && !slot_rst_n, "R4 waits for pgood", {slot_pwr_en, slot_rst_n}, 2);
    pgood = 1'b1;
    @(negedge clk);
    pgood = 1'b0;
    @(negedge clk);
    chk(!slot_rst_n, "R4 single pulse ignored", slot_rst_n, 0);
    pgood = 1'b1;
    @(negedge clk);
    chk(!slot_rst_n, "R4 first high sample", slot_rst_n, 0);
    @(negedge clk);
    chk(slot_rst_n, "R4 second high sample", slot_rst_n, 1);

    cur_req = "R5";
    repeat (3) @(negedge clk);
    pgood = 1'b0;
    @(negedge clk);
    chk(!slot_rst_n && slot_pwr_en, "R5 reset on pgood loss", {slot_rst_n, slot_pwr_en}, 1);
    pgood = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(slot_rst_n, "R5 re-release", slot_rst_n, 1);

    power_off(2, -1, 0, "R6");
    repeat (5) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #160000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule